// File: doc/BRIEF.md
# Multi-mode 8-bit timer counter

This block is the counting core of a general-purpose timer. A register holds the count. It advances by one step on each cycle in which the upstream clock-select stage raises the tick enable. A two-bit mode input selects one of four counting sequences:

- free-running up count;
- up count that clears after the count meets a compare value;
- single-slope sawtooth;
- dual-slope triangle.

Each sequence has its own rule for raising a sticky overflow flag. An interrupt controller or software reads that flag and clears it again.

A CPU port can load the count at any time, whether or not ticks arrive, and such a load beats every count or clear due in that cycle. The block also outputs:

- the count direction;
- TOP and BOTTOM indicators, which a waveform stage downstream can use.

Prescaling, clock selection, pin synchronisation and waveform generation are outside this block.

Top module: `tmr_core`

## Requirements
- R1: With mode_i = 0 (free-running), each tick adds one to the count. The count wraps from the all-ones value MAX to 0, and the tick that makes the count 0 sets ovf_o.
- R2: With mode_i = 2 (clear-on-compare), a tick taken while the count equals cmp_i loads 0, so the period is cmp_i+1 ticks. If cmp_i is below the count, the counter climbs to MAX and wraps before it can match. The tick that moves the count from MAX to 0 sets ovf_o.
- R3: With mode_i = 3 (single-slope), the count climbs from 0 to MAX and then restarts at 0. The tick that brings the count to MAX sets ovf_o.
- R4: With mode_i = 1 (dual-slope), the count climbs to MAX, holds MAX for exactly one tick, and then falls to 0 before it climbs again. down_o rises on the tick that reaches MAX and falls on the tick that reaches 0. The tick that reaches 0 sets ovf_o.
- R5: When cnt_we_i is high, the count takes cnt_wdata_i on the next edge, whatever the tick, the mode or a pending clear. No overflow is set by that cycle.
- R6: While tick_i is low, the count holds its value, and a CPU load still takes effect.
- R7: ovf_o stays set until a cycle with ovf_clr_i or ovf_ack_i high clears it.
- R8: A set event in the same cycle as a clear request leaves ovf_o set.
- R9: After reset the count is 0, down_o is 0 and ovf_o is 0.
- R10: top_o is high while the count equals cmp_i in mode 2, or equals MAX in the other modes. bottom_o is high while the count is 0.
- R11: One cycle after any cycle with a mode other than 1, down_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable from the clock-select stage |
| mode_i | input | 2 | Counting sequence select (0 free, 1 dual-slope, 2 clear-on-compare, 3 single-slope) |
| cmp_i | input | W | Compare value |
| cnt_we_i | input | 1 | CPU write strobe for the count |
| cnt_wdata_i | input | W | CPU write data for the count |
| ovf_clr_i | input | 1 | Write-one clear of the overflow flag |
| ovf_ack_i | input | 1 | Interrupt-acknowledge clear of the overflow flag |
| cnt_o | output | W | Current count |
| down_o | output | 1 | Count direction, 1 = falling |
| top_o | output | 1 | Count is at the top of the current sequence |
| bottom_o | output | 1 | Count is 0 |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench builds the counter with W = 4, so MAX is 15. At that width a full sawtooth takes 16 ticks and a full triangle takes 30. Every count value, every direction turn and every wrap in each mode therefore fits into short sweeps whose expected counts follow from modular arithmetic. The narrow width also lets the bench try all sixteen compare values in clear-on-compare mode, including the compare at 0 and at MAX. It also runs the case where the compare value is written below the running count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_FREE   = 2'd0,
    MODE_DUAL   = 2'd1,
    MODE_CLEAR  = 2'd2,
    MODE_SINGLE = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/tmr_step.sv
// Combinational next-count, next-direction and overflow-event logic.
module tmr_step
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] cnt_i,
  input  logic         dn_i,
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] cmp_i,
  output logic [W-1:0] nxt_cnt_o,
  output logic         nxt_dn_o,
  output logic         evt_o
);
  localparam logic [W-1:0] MAX  = {W{1'b1}};
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] inc, dec;
  logic         fall;

  assign inc = cnt_i + ONE;
  assign dec = cnt_i - ONE;

  always_comb begin
    nxt_cnt_o = inc;
    nxt_dn_o  = 1'b0;
    evt_o     = 1'b0;
    fall      = 1'b0;
    unique case (tmr_mode_e'(mode_i))
      MODE_FREE: begin
        nxt_cnt_o = inc;
        evt_o     = (cnt_i == MAX);
      end
      MODE_CLEAR: begin
        nxt_cnt_o = (cnt_i == cmp_i) ? ZERO : inc;
        evt_o     = (cnt_i == MAX);
      end
      MODE_SINGLE: begin
        nxt_cnt_o = (cnt_i == MAX) ? ZERO : inc;
        evt_o     = (inc == MAX);
      end
      MODE_DUAL: begin
        fall      = (cnt_i == MAX) || (dn_i && (cnt_i != ZERO));
        nxt_cnt_o = fall ? dec : inc;
        if (nxt_cnt_o == MAX)       nxt_dn_o = 1'b1;
        else if (nxt_cnt_o == ZERO) nxt_dn_o = 1'b0;
        else                        nxt_dn_o = fall;
        evt_o     = fall && (cnt_i == ONE);
      end
      default: begin
        nxt_cnt_o = inc;
      end
    endcase
  end
endmodule

// File: rtl/tmr_cnt_reg.sv
// Count and direction registers; CPU load has top priority.
module tmr_cnt_reg
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [1:0]   mode_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] nxt_cnt_i,
  input  logic         nxt_dn_i,
  output logic [W-1:0] cnt_o,
  output logic         dn_o
);
  logic [W-1:0] cnt_d;
  logic         dn_d;
  logic         adv;

  assign adv = tick_i && !we_i;

  always_comb begin
    cnt_d = cnt_o;
    if (we_i)       cnt_d = wdata_i;
    else if (adv)   cnt_d = nxt_cnt_i;
  end

  always_comb begin
    dn_d = dn_o;
    if (tmr_mode_e'(mode_i) != MODE_DUAL) dn_d = 1'b0;
    else if (adv)                         dn_d = nxt_dn_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      dn_o  <= 1'b0;
    end else begin
      cnt_o <= cnt_d;
      dn_o  <= dn_d;
    end
  end
endmodule

// File: rtl/tmr_flag.sv
// Sticky flag: set wins over clear.
module tmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_d;

  always_comb begin
    flag_d = flag_o;
    if (set_i)      flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else         flag_o <= flag_d;
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] cmp_i,
  input  logic         cnt_we_i,
  input  logic [W-1:0] cnt_wdata_i,
  input  logic         ovf_clr_i,
  input  logic         ovf_ack_i,
  output logic [W-1:0] cnt_o,
  output logic         down_o,
  output logic         top_o,
  output logic         bottom_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] nxt_cnt;
  logic         nxt_dn;
  logic         evt;
  logic         ovf_set;
  logic [W-1:0] top_val;

  tmr_step #(.W(W)) u_step (
    .cnt_i     (cnt_o),
    .dn_i      (down_o),
    .mode_i    (mode_i),
    .cmp_i     (cmp_i),
    .nxt_cnt_o (nxt_cnt),
    .nxt_dn_o  (nxt_dn),
    .evt_o     (evt)
  );

  tmr_cnt_reg #(.W(W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .mode_i    (mode_i),
    .we_i      (cnt_we_i),
    .wdata_i   (cnt_wdata_i),
    .nxt_cnt_i (nxt_cnt),
    .nxt_dn_i  (nxt_dn),
    .cnt_o     (cnt_o),
    .dn_o      (down_o)
  );

  assign ovf_set = tick_i && !cnt_we_i && evt;

  tmr_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ovf_set),
    .clr_i  (ovf_clr_i || ovf_ack_i),
    .flag_o (ovf_o)
  );

  assign top_val  = (tmr_mode_e'(mode_i) == MODE_CLEAR) ? cmp_i : MAX;
  assign top_o    = (cnt_o == top_val);
  assign bottom_o = (cnt_o == '0);
endmodule

// File: rtl/tmr_core_chk.sv
module tmr_core_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic [1:0]   mode_i,
  input logic [W-1:0] cmp_i,
  input logic         cnt_we_i,
  input logic [W-1:0] cnt_wdata_i,
  input logic         ovf_clr_i,
  input logic         ovf_ack_i,
  input logic [W-1:0] cnt_o,
  input logic         down_o,
  input logic         ovf_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  AST_FREE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && tick_i && !cnt_we_i) |=> (cnt_o == $past(cnt_o) + ONE)); // R1
  AST_CLEAR_AT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2 && tick_i && !cnt_we_i && cnt_o == cmp_i) |=> (cnt_o == '0)); // R2
  AST_DUAL_PEAK_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && tick_i && !cnt_we_i && cnt_o == MAX) |=> (cnt_o == MAX - ONE)); // R4
  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i |=> (cnt_o == $past(cnt_wdata_i))); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cnt_we_i) |=> $stable(cnt_o)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i && !ovf_ack_i) |=> ovf_o); // R7
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && tick_i && !cnt_we_i && cnt_o == MAX) |=> ovf_o); // R8
  AST_UP_OUTSIDE_DUAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'd1) |=> !down_o); // R11
endmodule

bind tmr_core tmr_core_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .mode_i      (mode_i),
  .cmp_i       (cmp_i),
  .cnt_we_i    (cnt_we_i),
  .cnt_wdata_i (cnt_wdata_i),
  .ovf_clr_i   (ovf_clr_i),
  .ovf_ack_i   (ovf_ack_i),
  .cnt_o       (cnt_o),
  .down_o      (down_o),
  .ovf_o       (ovf_o)
);

// File: tb/tmr_core_tb_top.sv
`timescale 1ns/1ps
module tmr_core_tb_top;
  localparam int W   = 4;
  localparam int MAX = (1 << W) - 1;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         tick_i;
  logic [1:0]   mode_i;
  logic [W-1:0] cmp_i;
  logic         cnt_we_i;
  logic [W-1:0] cnt_wdata_i;
  logic         ovf_clr_i;
  logic         ovf_ack_i;
  logic [W-1:0] cnt_o;
  logic         down_o, top_o, bottom_o, ovf_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  tmr_core #(.W(W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .mode_i(mode_i),
    .cmp_i(cmp_i), .cnt_we_i(cnt_we_i), .cnt_wdata_i(cnt_wdata_i),
    .ovf_clr_i(ovf_clr_i), .ovf_ack_i(ovf_ack_i), .cnt_o(cnt_o),
    .down_o(down_o), .top_o(top_o), .bottom_o(bottom_o), .ovf_o(ovf_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock: drive at falling edge, sample 1 ns after rising edge.
  task automatic cyc(input bit t, input bit we, input int wd, input bit clr, input bit ack);
    @(negedge clk_i);
    tick_i = t; cnt_we_i = we; cnt_wdata_i = W'(wd);
    ovf_clr_i = clr; ovf_ack_i = ack;
    @(posedge clk_i);
    #1;
  endtask

  // Load count, clear flag, no tick.
  task automatic prep(input int m, input int v);
    @(negedge clk_i);
    mode_i = 2'(m);
    cyc(0, 1, v, 1, 0);
  endtask

  initial begin
    rst_ni = 1'b0; tick_i = 0; mode_i = 0; cmp_i = 0;
    cnt_we_i = 0; cnt_wdata_i = 0; ovf_clr_i = 0; ovf_ack_i = 0;
    repeat (3) @(posedge clk_i);
    #1;
    // R9 reset state
    chk("R9 cnt", int'(cnt_o), 0);
    chk("R9 down", int'(down_o), 0);
    chk("R9 ovf", int'(ovf_o), 0);
    chk("R10 bottom at reset", int'(bottom_o), 1);
    @(negedge clk_i); rst_ni = 1'b1;

    // R1 free-running sweep
    prep(0, 0);
    for (int k = 1; k <= 40; k++) begin
      cyc(1, 0, 0, 0, 0);
      chk("R1 count", int'(cnt_o), k % (MAX + 1));
      chk("R1 flag", int'(ovf_o), (k > MAX) ? 1 : 0);
      chk("R10 top free", int'(top_o), ((k % (MAX + 1)) == MAX) ? 1 : 0);
      chk("R10 bottom free", int'(bottom_o), ((k % (MAX + 1)) == 0) ? 1 : 0);
    end

    // R3 single-slope sweep
    prep(3, 0);
    for (int k = 1; k <= 40; k++) begin
      cyc(1, 0, 0, 0, 0);
      chk("R3 count", int'(cnt_o), k % (MAX + 1));
      chk("R3 flag", int'(ovf_o), (k >= MAX) ? 1 : 0);
    end

    // R4 dual-slope sweep, with R11 before it
    prep(0, 0);
    @(negedge clk_i); mode_i = 2'd1;
    for (int k = 1; k <= 2 * (2 * MAX) + 3; k++) begin
      int p;
      p = k % (2 * MAX);
      cyc(1, 0, 0, 0, 0);
      chk("R4 count", int'(cnt_o), (p <= MAX) ? p : (2 * MAX - p));
      chk("R4 down", int'(down_o), (p >= MAX) ? 1 : 0);
      chk("R4 flag", int'(ovf_o), (k >= 2 * MAX) ? 1 : 0);
    end
    // R11: leave dual mode while falling
    prep(1, 8);
    cyc(1, 1, MAX, 0, 0);
    cyc(1, 0, 0, 0, 0);
    chk("R4 falling after peak", int'(down_o), 1);
    @(negedge clk_i); mode_i = 2'd0;
    cyc(0, 0, 0, 0, 0);
    chk("R11 down cleared", int'(down_o), 0);

    // R2 every compare value
    for (int c = 0; c <= MAX; c++) begin
      cmp_i = W'(c);
      prep(2, 0);
      for (int k = 1; k <= 2 * (c + 1) + 1; k++) begin
        cyc(1, 0, 0, 0, 0);
        chk("R2 count", int'(cnt_o), k % (c + 1));
        chk("R10 top clear", int'(top_o), ((k % (c + 1)) == c) ? 1 : 0);
      end
    end
    // R2 compare below count: climb and wrap
    cmp_i = 4'd3;
    prep(2, 10);
    for (int k = 1; k <= 10; k++) begin
      cyc(1, 0, 0, 0, 0);
      chk("R2 missed match count", int'(cnt_o), (k <= 5) ? 10 + k : ((k <= 9) ? k - 6 : 0));
      chk("R2 wrap flag", int'(ovf_o), (k >= 6) ? 1 : 0);
    end

    // R5 write beats clear at match and beats dual peak
    prep(2, 3);
    cyc(1, 1, 9, 0, 0);
    chk("R5 write over clear", int'(cnt_o), 9);
    prep(1, MAX);
    cyc(1, 1, 7, 0, 0);
    chk("R5 write over dual", int'(cnt_o), 7);
    prep(0, MAX);
    cyc(1, 1, 2, 0, 0);
    chk("R5 no flag on write", int'(ovf_o), 0);

    // R6 hold without ticks, write still works
    prep(0, 6);
    for (int k = 0; k < 5; k++) begin
      cyc(0, 0, 0, 0, 0);
      chk("R6 hold", int'(cnt_o), 6);
    end
    cyc(0, 1, 12, 0, 0);
    chk("R6 write idle", int'(cnt_o), 12);

    // R7 sticky, cleared by write-one and by ack
    prep(0, MAX);
    cyc(1, 0, 0, 0, 0);
    chk("R7 set", int'(ovf_o), 1);
    repeat (3) cyc(1, 0, 0, 0, 0);
    chk("R7 sticky", int'(ovf_o), 1);
    cyc(0, 0, 0, 1, 0);
    chk("R7 write-one clear", int'(ovf_o), 0);
    prep(0, MAX);
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R7 ack clear", int'(ovf_o), 0);

    // R8 set beats clear
    prep(0, MAX);
    cyc(1, 0, 0, 1, 1);
    chk("R8 set wins", int'(ovf_o), 1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule